// File: doc/BRIEF.md
# Maximal-Length Shift-Register Pulse Divider

This block divides its clock by a large fixed ratio using a free-running linear feedback shift register instead of a binary counter. The register shifts by one place toward bit 0 every clock and feeds a two-bit XOR back into its top bit. The next-state logic is one XOR gate, whatever the width, so the register runs at the full fabric clock rate. A one-clock pulse marks one fixed point in the sequence. The current register value is also brought out for debug.

Two ways of spotting that point are offered, chosen by a parameter. The parallel decoder looks for the all-ones state. It splits the wide AND into registered groups of a few bits and then registers their combination, so no decode path is wider than one group. The serial decoder only watches the bit leaving the register at bit 0. It fires once that bit has been zero on a set number of consecutive clocks. With a run length of one less than the width, this happens exactly once per sequence.

The default length is 15 bits with feedback from bits 0 and 1. This choice gives the maximal period of 32767 clocks, because two-tap feedback cannot reach the maximal period at every width. The reset is synchronous and active high.

Top module: `lfsr_pulse_div`

## Requirements
- R1: While `rst` is high at a clock edge, the register loads a seed with a 1 in the most significant bit and 0 in every other bit, and `pulse_o` is 0 after that edge.
- R2: `state_o` is never all zeros.
- R3: On each clock without reset, bits [W-2:0] take the old bits [W-1:1], and bit W-1 takes old bit 0 XOR old bit TAP (default W=15, TAP=1).
- R4: In parallel mode (DECODE_MODE=DEC_PARALLEL, encoded 0), `pulse_o` is 1 exactly two clocks after `state_o` shows all ones, and is 0 otherwise.
- R5: Every pulse is exactly one clock wide.
- R6: Successive pulses are exactly 2^W-1 clocks apart (32767 by default).
- R7: In serial mode (DECODE_MODE=DEC_ZERO_RUN, encoded 1), `pulse_o` is 1 in the clock after the edge at which `state_o[0]` has been 0 on RUN_LEN consecutive edges (default W-1). It does not rise again until a 1 breaks the run.
- R8: A reset edge that comes one clock after the all-ones state cancels the pending parallel-mode pulse.
- R9: After any reset, the first pulse comes the same number of clocks after reset release as after the first reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_o | output | 1 | One-clock divided pulse, registered |
| state_o | output | WIDTH | Current shift-register value (debug) |

## Verification
The hardest case to reach is a reset that lands while a terminal-state decode is still inside the two-stage pipeline. The register cannot be preloaded, so the bench lets it run through whole periods. It tracks the sequence in its own model, waits until the all-ones value shows on `state_o`, and raises reset in that very cycle. A pulse two cycles later would then be a failure. After that reset, the bench times the next pulse against the first one seen after power-up. A second instance in serial mode runs next to the first, so both decoders are held to the same period.

// File: rtl/lfsr_div_pkg.sv
package lfsr_div_pkg;

  typedef enum logic {
    DEC_PARALLEL = 1'b0,
    DEC_ZERO_RUN = 1'b1
  } dec_mode_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/lfsr_core.sv
module lfsr_core #(
  parameter int WIDTH = 15,
  parameter int TAP   = 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] state_o
);

  localparam logic [WIDTH-1:0] SEED = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] state_q;
  logic             fb;

  assign fb = state_q[0] ^ state_q[TAP];

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= {fb, state_q[WIDTH-1:1]};
  end

  assign state_o = state_q;

  logic armed_q;
  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b1;
  end

  AST_SEED_NONZERO: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (state_q != '0)); // R2
  AST_SHIFT_BODY: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !$past(rst)) |-> (state_q[WIDTH-2:0] == $past(state_q[WIDTH-1:1]))); // R3
  AST_FEEDBACK: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !$past(rst)) |-> (state_q[WIDTH-1] == ($past(state_q[0]) ^ $past(state_q[TAP])))); // R3

endmodule

// File: rtl/and_pipe.sv
module and_pipe #(
  parameter int WIDTH = 15,
  parameter int GROUP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] vec_i,
  output logic             hit_o
);

  localparam int NGRP = lfsr_div_pkg::ceil_div(WIDTH, GROUP);

  logic [NGRP-1:0] grp_d;
  logic [NGRP-1:0] grp_q;
  logic            hit_q;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    localparam int LO = gi * GROUP;
    localparam int HI = (LO + GROUP > WIDTH) ? WIDTH - 1 : LO + GROUP - 1;
    assign grp_d[gi] = &vec_i[HI:LO];
  end

  // stage one: per-group partial products
  always_ff @(posedge clk) begin
    if (rst) grp_q <= '0;
    else     grp_q <= grp_d;
  end

  // stage two: combine the groups
  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= &grp_q;
  end

  assign hit_o = hit_q;

  logic [1:0] vld_q;
  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[0], 1'b1};
  end

  AST_DECODE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    vld_q[1] |-> (hit_o == (&$past(vec_i, 2)))); // R4
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (vld_q[1] && hit_o) |=> !hit_o); // R5

endmodule

// File: rtl/zero_run_det.sv
module zero_run_det #(
  parameter int RUN_LEN = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_i,
  output logic hit_o
);

  localparam int            CW   = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);
  localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

  logic [CW-1:0] cnt_q;
  logic          hit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else if (bit_i) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      hit_q <= (cnt_q == LAST);
    end
  end

  assign hit_o = hit_q;

  logic armed_q;
  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b1;
  end

  AST_ZR_AFTER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !$past(rst) && hit_o) |-> !$past(bit_i)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (cnt_q <= FULL)); // R7
  AST_ZR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (armed_q && hit_o) |=> !hit_o); // R5

endmodule

// File: rtl/lfsr_pulse_div.sv
module lfsr_pulse_div #(
  parameter int                      WIDTH       = 15,
  parameter int                      TAP         = 1,
  parameter int                      GROUP       = 4,
  parameter lfsr_div_pkg::dec_mode_e DECODE_MODE = lfsr_div_pkg::DEC_PARALLEL,
  parameter int                      RUN_LEN     = WIDTH - 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic             pulse_o,
  output logic [WIDTH-1:0] state_o
);

  localparam logic [WIDTH:0] PERIOD = {1'b0, {WIDTH{1'b1}}};

  logic [WIDTH-1:0] core_state;

  lfsr_core #(.WIDTH(WIDTH), .TAP(TAP)) u_core (
    .clk     (clk),
    .rst     (rst),
    .state_o (core_state)
  );

  if (DECODE_MODE == lfsr_div_pkg::DEC_PARALLEL) begin : g_par
    and_pipe #(.WIDTH(WIDTH), .GROUP(GROUP)) u_dec (
      .clk   (clk),
      .rst   (rst),
      .vec_i (core_state),
      .hit_o (pulse_o)
    );
  end else begin : g_zr
    zero_run_det #(.RUN_LEN(RUN_LEN)) u_dec (
      .clk   (clk),
      .rst   (rst),
      .bit_i (core_state[0]),
      .hit_o (pulse_o)
    );
  end

  assign state_o = core_state;

  // spacing monitor for the period property
  logic [WIDTH:0] since_q;
  logic           seen_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (pulse_o) begin
      since_q <= (WIDTH+1)'(1);
      seen_q  <= 1'b1;
    end else if (since_q != '1) begin
      since_q <= since_q + 1'b1;
    end
  end

  AST_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (seen_q && pulse_o) |-> (since_q == PERIOD)); // R6

endmodule

// File: tb/lfsr_pulse_div_test.sv
module lfsr_pulse_div_test;

  localparam int W   = 15;
  localparam int TAP = 1;
  localparam int RUN = W - 1;
  localparam longint PER = (64'd1 << W) - 1;
  localparam logic [W-1:0] SEED = {1'b1, {(W-1){1'b0}}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic         p_par, p_zr;
  logic [W-1:0] st_par, st_zr;

  lfsr_pulse_div #(.WIDTH(W), .TAP(TAP)) uut (
    .clk(clk), .rst(rst), .pulse_o(p_par), .state_o(st_par));

  lfsr_pulse_div #(.WIDTH(W), .TAP(TAP),
                   .DECODE_MODE(lfsr_div_pkg::DEC_ZERO_RUN)) uut_zr (
    .clk(clk), .rst(rst), .pulse_o(p_zr), .state_o(st_zr));

  int     n_run = 0;
  int     n_fail = 0;
  longint cyc = 0;
  bit     live = 0;
  bit     done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural reference: sequence value, two-deep delay of the all-ones flag, run length
  logic [W-1:0] m_st;
  bit           m_a, m_p, m_zp;
  int           m_run;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_st = SEED; m_a = 0; m_p = 0; m_zp = 0; m_run = 0;
    end else begin
      m_p = m_a;
      m_a = (m_st == '1);
      if (m_st[0] == 1'b0) begin
        m_run++;
        m_zp = (m_run == RUN);
      end else begin
        m_run = 0;
        m_zp  = 0;
      end
      m_st = {m_st[0] ^ m_st[TAP], m_st[W-1:1]};
    end
  end

  // pulse bookkeeping
  bit     prev_par = 0, prev_zr = 0;
  longint last_par = -1, last_zr = -1;
  int     npar = 0, nzr = 0;
  int     epoch = 0;
  longint rel_at = 0;
  longint off_par[2] = '{-1, -1};
  longint off_zr[2]  = '{-1, -1};

  always @(negedge clk) begin
    if (live) begin
      chk(st_par == m_st, "R3 parallel state", st_par, m_st);
      chk(st_zr == m_st, "R3 serial state", st_zr, m_st);
      chk(st_par != '0, "R2 nonzero", st_par, 1);
      chk(p_par == m_p, "R4 parallel pulse", p_par, m_p);
      chk(p_zr == m_zp, "R7 serial pulse", p_zr, m_zp);
      if (p_par) begin
        chk(!prev_par, "R5 parallel width", 2, 1);
        if (last_par >= 0) chk(cyc - last_par == PER, "R6 parallel spacing", cyc - last_par, PER);
        if (off_par[epoch] < 0) off_par[epoch] = cyc - rel_at;
        last_par = cyc;
        npar++;
      end
      if (p_zr) begin
        chk(!prev_zr, "R5 serial width", 2, 1);
        if (last_zr >= 0) chk(cyc - last_zr == PER, "R6 serial spacing", cyc - last_zr, PER);
        if (off_zr[epoch] < 0) off_zr[epoch] = cyc - rel_at;
        last_zr = cyc;
        nzr++;
      end
      prev_par = p_par;
      prev_zr  = p_zr;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(st_par == SEED, "R1 reset seed", st_par, SEED);
    chk(st_zr == SEED, "R1 reset seed serial", st_zr, SEED);
    chk(p_par == 1'b0, "R1 pulse low in reset", p_par, 0);
    chk(p_zr == 1'b0, "R1 serial pulse low in reset", p_zr, 0);
    live   = 1;
    rst    = 1'b0;
    rel_at = cyc;

    wait (npar >= 2 && nzr >= 2);

    // R8: reset right after the all-ones state shows up
    do @(negedge clk); while (st_par != '1);
    rst = 1'b1;
    @(negedge clk);
    chk(st_par == SEED, "R1 mid-run reset seed", st_par, SEED);
    chk(p_par == 1'b0, "R8 pulse cleared by reset", p_par, 0);
    rst      = 1'b0;
    epoch    = 1;
    rel_at   = cyc;
    npar     = 0;
    nzr      = 0;
    last_par = -1;
    last_zr  = -1;
    @(negedge clk);
    chk(p_par == 1'b0, "R8 no pulse after cancelled decode", p_par, 0);

    wait (npar >= 1 && nzr >= 1);
    @(negedge clk);
    chk(off_par[1] == off_par[0], "R9 parallel restart offset", off_par[1], off_par[0]);
    chk(off_zr[1] == off_zr[0], "R9 serial restart offset", off_zr[1], off_zr[0]);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule